// File: doc/BRIEF.md
# Descriptor Chain DMA Sequencer

This block is a single-channel engine that walks a linked chain of 16-byte command descriptors held in memory. Whenever it is idle and the control unit holds both its run and active levels high, it reads the descriptor at the command pointer as four 32-bit words and decodes it. Depending on the command, it then starts a transfer on a device-side port, moves a word between memory and the descriptor's dependent word, does nothing, or halts. It can also reject the descriptor and kill the channel.

When a device transfer finishes, the sequencer writes the channel status and the residual count into the descriptor's last word in memory. It then raises an optional interrupt and holds while a wait condition is true. After that it either branches to the address held in the dependent word or steps to the next descriptor. Wait, branch and interrupt conditions are judged by an external evaluator. The evaluator sees the current command halfword and returns three hit bits.

The descriptor words are laid out at the command pointer as follows:

- Word 0: the request count in bits [15:0] and the command in bits [31:16].
- Word 1: the data address.
- Word 2: the dependent word.
- Word 3: the residual count in bits [15:0] and the transfer status in bits [31:16].

The fields of the command halfword are:

- Bits [15:12]: opcode.
- Bits [10:8]: key.
- Bits [5:4]: interrupt selector.
- Bits [3:2]: branch selector.
- Bits [1:0]: wait selector.

The selectors are only passed to the evaluator.

Top module: `desc_seq`

## Requirements
- R1: While rst is high, and after it is released, every request, strobe and pulse output is low, and cmd_ptr_o and bt_o are zero.
- R2: A fetch starts only from idle with run_i and active_i both high. It issues four word reads at cmd_ptr_o, +4, +8 and +12.
- R3: Opcodes 0, 1, 2 and 3 are out-more, out-last, in-more and in-last. Each gives a one-cycle xfer_start_o with xfer_addr_o set to word 1 and xfer_len_o set to the request count. xfer_out_o is high for opcodes 0 and 1, and xfer_last_o is high for opcodes 1 and 3.
- R4: The channel is killed by a transfer whose address is zero, a transfer whose key is above 3, or an opcode above 7. A kill gives a one-cycle kill_o, starts no transfer and leaves the pointer unchanged.
- R5: Opcode 7 (stop) gives a one-cycle halt_o and leaves the pointer unchanged. No new fetch starts until active_i has been low.
- R6: On xfer_done_i, the sequencer writes word 3 of the descriptor at cmd_ptr_o+12 with all byte enables set. The data is {status, xfer_resid_i}, where status bit 0 is run, bit 1 active, bit 2 wake and bit 3 BT, and all other status bits are zero.
- R7: A wake_set_i pulse sets the wake flag, and the start of each fetch clears it. If both happen in the same cycle, the clear wins.
- R8: Opcode 4 (load) with key 6 reads the word at the word-aligned data address. For a request count of 1, 2 or other, the low 1, 2 or 4 bytes of that word replace the same bytes of the dependent word. The result is then written to cmd_ptr_o+8.
- R9: Opcode 5 (store) with key 6 writes the dependent word to the word-aligned data address. The byte enables are 0001, 0011 or 1111 for a request count of 1, 2 or other.
- R10: A load or store with a key other than 6 makes no memory access and the chain still advances.
- R11: After a transfer or a nop (opcode 6), branch_hit_i moves the pointer to the dependent word and sets bt_o. Otherwise, and after any load or store, the pointer steps by 16 and bt_o clears.
- R12: After a command completes, the pointer holds while wait_hit_i is high.
- R13: irq_o pulses for exactly one cycle after a transfer or nop completes with irq_hit_i high.
- R14: cp_load_i loads cp_val_i into the pointer only while active_i is low. While active_i is high it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Run level from the control unit |
| active_i | input | 1 | Active level from the control unit |
| wake_set_i | input | 1 | Pulse that sets the wake flag |
| cp_load_i | input | 1 | Command pointer load strobe |
| cp_val_i | input | AW | Command pointer load value |
| cmd_ptr_o | output | AW | Current command pointer |
| bt_o | output | 1 | Branch-taken flag |
| cur_cmd_o | output | 16 | Command halfword of the current descriptor, for the evaluator |
| wait_hit_i | input | 1 | Wait condition true |
| branch_hit_i | input | 1 | Branch condition true |
| irq_hit_i | input | 1 | Interrupt condition true |
| irq_o | output | 1 | Interrupt pulse |
| kill_o | output | 1 | Kill pulse to the control unit |
| halt_o | output | 1 | Stop pulse to the control unit |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory byte address, word aligned |
| mem_wdata_o | output | 32 | Memory write data |
| mem_be_o | output | 4 | Memory byte enables |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Memory read data, valid with the acknowledge |
| xfer_start_o | output | 1 | Device transfer start pulse |
| xfer_out_o | output | 1 | Transfer direction, 1 for memory to device |
| xfer_last_o | output | 1 | Last-transfer flag |
| xfer_addr_o | output | 32 | Transfer data address |
| xfer_len_o | output | 16 | Transfer request count |
| xfer_done_i | input | 1 | Device transfer completion |
| xfer_resid_i | input | 16 | Residual count at completion |

## Verification
Setting the wake flag and clearing it at fetch start can land on the same clock edge. The bench provokes this by raising run_i, active_i and wake_set_i on one edge while the sequencer is idle. It judges the outcome from the status word written back by the first transfer, which must show wake clear. A later wake_set_i pulse is given in the middle of a transfer that is followed by a held wait. Its write-back must show wake set, proving the flag itself works. A scoreboard compares every memory write and every transfer start against the queued expectation.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_DECODE, S_XFER, S_WBACK, S_WORD, S_DONE, S_WAIT, S_PARK
  } dsq_state_e;

  localparam logic [3:0] OP_OUT_MORE = 4'd0;
  localparam logic [3:0] OP_OUT_LAST = 4'd1;
  localparam logic [3:0] OP_IN_MORE  = 4'd2;
  localparam logic [3:0] OP_IN_LAST  = 4'd3;
  localparam logic [3:0] OP_LOAD     = 4'd4;
  localparam logic [3:0] OP_STORE    = 4'd5;
  localparam logic [3:0] OP_NOP      = 4'd6;
  localparam logic [3:0] OP_STOP     = 4'd7;

  typedef struct packed {
    logic xfer;
    logic out;
    logic last;
    logic load;
    logic store;
    logic nop;
    logic stop;
    logic bad;
    logic sys;
  } dsq_cls_t;

endpackage

// File: rtl/dsq_decode.sv
module dsq_decode
  import dsq_pkg::*;
#(
  parameter int KEYW           = 3,
  parameter int KEY_STREAM_MAX = 3,
  parameter int KEY_SYS        = 6
) (
  input  logic [3:0]      opcode,
  input  logic [KEYW-1:0] key,
  input  logic [31:0]     daddr,
  output dsq_cls_t        cls
);

  always_comb begin
    cls = '0;
    cls.sys = (key == KEYW'(KEY_SYS));
    case (opcode)
      OP_OUT_MORE: begin cls.xfer = 1'b1; cls.out = 1'b1; end
      OP_OUT_LAST: begin cls.xfer = 1'b1; cls.out = 1'b1; cls.last = 1'b1; end
      OP_IN_MORE:  cls.xfer = 1'b1;
      OP_IN_LAST:  begin cls.xfer = 1'b1; cls.last = 1'b1; end
      OP_LOAD:     cls.load = 1'b1;
      OP_STORE:    cls.store = 1'b1;
      OP_NOP:      cls.nop = 1'b1;
      OP_STOP:     cls.stop = 1'b1;
      default:     cls.bad = 1'b1;
    endcase
    // transfers need a real address and a stream key
    if (cls.xfer && (daddr == '0 || key > KEYW'(KEY_STREAM_MAX)))
      cls.bad = 1'b1;
  end

endmodule

// File: rtl/dsq_wordlane.sv
module dsq_wordlane #(
  parameter int DW = 32
) (
  input  logic [15:0]     count,
  input  logic [DW-1:0]   old_dep,
  input  logic [DW-1:0]   rd_word,
  output logic [DW/8-1:0] be,
  output logic [DW-1:0]   merged
);

  localparam int NB = DW / 8;

  always_comb begin
    if (count == 16'd1)      be = {{(NB-1){1'b0}}, 1'b1};
    else if (count == 16'd2) be = {{(NB-2){1'b0}}, 2'b11};
    else                     be = '1;
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign merged[8*b +: 8] = be[b] ? rd_word[8*b +: 8] : old_dep[8*b +: 8];
  end

endmodule

// File: rtl/dsq_ptr.sv
module dsq_ptr #(
  parameter int AW   = 32,
  parameter int STEP = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  input  logic          br,
  input  logic [AW-1:0] target,
  output logic [AW-1:0] ptr,
  output logic          bt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
      bt  <= 1'b0;
    end else if (load) begin
      ptr <= load_val;
    end else if (adv) begin
      if (br) begin
        ptr <= target;
        bt  <= 1'b1;
      end else begin
        ptr <= ptr + AW'(STEP);
        bt  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/desc_seq.sv
module desc_seq
  import dsq_pkg::*;
#(
  parameter int AW             = 32,
  parameter int KEY_STREAM_MAX = 3,
  parameter int KEY_SYS        = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic          active_i,
  input  logic          wake_set_i,
  input  logic          cp_load_i,
  input  logic [AW-1:0] cp_val_i,
  output logic [AW-1:0] cmd_ptr_o,
  output logic          bt_o,
  output logic [15:0]   cur_cmd_o,
  input  logic          wait_hit_i,
  input  logic          branch_hit_i,
  input  logic          irq_hit_i,
  output logic          irq_o,
  output logic          kill_o,
  output logic          halt_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  output logic [3:0]    mem_be_o,
  input  logic          mem_ack_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          xfer_start_o,
  output logic          xfer_out_o,
  output logic          xfer_last_o,
  output logic [31:0]   xfer_addr_o,
  output logic [15:0]   xfer_len_o,
  input  logic          xfer_done_i,
  input  logic [15:0]   xfer_resid_i
);

  localparam int DW         = 32;
  localparam int WORD_BYTES = DW / 8;
  localparam int DESC_BYTES = 16;
  localparam int DESC_WORDS = DESC_BYTES / WORD_BYTES;
  localparam int WIDX_W     = $clog2(DESC_WORDS);
  localparam int DEP_OFS    = 2 * WORD_BYTES;
  localparam int STAT_OFS   = 3 * WORD_BYTES;

  dsq_state_e         state;
  logic [WIDX_W-1:0]  widx;
  logic [DW-1:0]      w_cmdcnt, w_addr, w_dep;
  logic               wake_q;
  dsq_cls_t           cls;
  logic [WORD_BYTES-1:0] lane_be;
  logic [DW-1:0]      merged;
  logic               ptr_load, ptr_adv, ptr_br;
  logic [15:0]        status;

  assign cur_cmd_o = w_cmdcnt[31:16];
  assign status    = {12'h000, bt_o, wake_q, active_i, run_i};

  dsq_decode #(
    .KEYW(3), .KEY_STREAM_MAX(KEY_STREAM_MAX), .KEY_SYS(KEY_SYS)
  ) u_dec (
    .opcode(w_cmdcnt[31:28]),
    .key   (w_cmdcnt[26:24]),
    .daddr (w_addr),
    .cls   (cls)
  );

  dsq_wordlane #(.DW(DW)) u_lane (
    .count  (w_cmdcnt[15:0]),
    .old_dep(w_dep),
    .rd_word(mem_rdata_i),
    .be     (lane_be),
    .merged (merged)
  );

  assign ptr_load = cp_load_i && !active_i && (state == S_IDLE || state == S_PARK);
  assign ptr_adv  = (state == S_WAIT) && !wait_hit_i;
  assign ptr_br   = (cls.xfer || cls.nop) && branch_hit_i;

  dsq_ptr #(.AW(AW), .STEP(DESC_BYTES)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .load    (ptr_load),
    .load_val(cp_val_i),
    .adv     (ptr_adv),
    .br      (ptr_br),
    .target  (w_dep[AW-1:0]),
    .ptr     (cmd_ptr_o),
    .bt      (bt_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      widx         <= '0;
      w_cmdcnt     <= '0;
      w_addr       <= '0;
      w_dep        <= '0;
      wake_q       <= 1'b0;
      irq_o        <= 1'b0;
      kill_o       <= 1'b0;
      halt_o       <= 1'b0;
      mem_req_o    <= 1'b0;
      mem_we_o     <= 1'b0;
      mem_addr_o   <= '0;
      mem_wdata_o  <= '0;
      mem_be_o     <= '0;
      xfer_start_o <= 1'b0;
      xfer_out_o   <= 1'b0;
      xfer_last_o  <= 1'b0;
      xfer_addr_o  <= '0;
      xfer_len_o   <= '0;
    end else begin
      irq_o        <= 1'b0;
      kill_o       <= 1'b0;
      halt_o       <= 1'b0;
      xfer_start_o <= 1'b0;
      if (wake_set_i) wake_q <= 1'b1;
      case (state)
        S_IDLE: begin
          if (run_i && active_i) begin
            wake_q     <= 1'b0;          // fetch clear wins over a set
            mem_req_o  <= 1'b1;
            mem_we_o   <= 1'b0;
            mem_be_o   <= '1;
            mem_addr_o <= cmd_ptr_o;
            widx       <= '0;
            state      <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (mem_ack_i) begin
            case (widx)
              WIDX_W'(0): w_cmdcnt <= mem_rdata_i;
              WIDX_W'(1): w_addr   <= mem_rdata_i;
              WIDX_W'(2): w_dep    <= mem_rdata_i;
              default: ;
            endcase
            if (widx == WIDX_W'(DESC_WORDS - 1)) begin
              mem_req_o <= 1'b0;
              state     <= S_DECODE;
            end else begin
              widx       <= widx + 1'b1;
              mem_addr_o <= mem_addr_o + AW'(WORD_BYTES);
            end
          end
        end
        S_DECODE: begin
          if (cls.bad) begin
            kill_o <= 1'b1;
            state  <= S_PARK;
          end else if (cls.stop) begin
            halt_o <= 1'b1;
            state  <= S_PARK;
          end else if (cls.xfer) begin
            xfer_start_o <= 1'b1;
            xfer_out_o   <= cls.out;
            xfer_last_o  <= cls.last;
            xfer_addr_o  <= w_addr;
            xfer_len_o   <= w_cmdcnt[15:0];
            state        <= S_XFER;
          end else if ((cls.load || cls.store) && cls.sys) begin
            mem_req_o   <= 1'b1;
            mem_we_o    <= cls.store;
            mem_addr_o  <= {w_addr[AW-1:2], 2'b00};
            mem_wdata_o <= w_dep;
            mem_be_o    <= lane_be;
            state       <= S_WORD;
          end else begin
            state <= S_DONE;
          end
        end
        S_XFER: begin
          if (xfer_done_i) begin
            mem_req_o   <= 1'b1;
            mem_we_o    <= 1'b1;
            mem_be_o    <= '1;
            mem_addr_o  <= cmd_ptr_o + AW'(STAT_OFS);
            mem_wdata_o <= {status, xfer_resid_i};
            state       <= S_WBACK;
          end
        end
        S_WORD: begin
          if (mem_ack_i) begin
            if (cls.load) begin
              w_dep       <= merged;
              mem_we_o    <= 1'b1;
              mem_be_o    <= '1;
              mem_addr_o  <= cmd_ptr_o + AW'(DEP_OFS);
              mem_wdata_o <= merged;
              state       <= S_WBACK;
            end else begin
              mem_req_o <= 1'b0;
              mem_we_o  <= 1'b0;
              state     <= S_DONE;
            end
          end
        end
        S_WBACK: begin
          if (mem_ack_i) begin
            mem_req_o <= 1'b0;
            mem_we_o  <= 1'b0;
            state     <= S_DONE;
          end
        end
        S_DONE: begin
          irq_o <= irq_hit_i && (cls.xfer || cls.nop);
          state <= S_WAIT;
        end
        S_WAIT: begin
          if (!wait_hit_i) state <= S_IDLE;
        end
        S_PARK: begin
          if (!active_i) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dsq_check.sv
module dsq_check #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          xfer_start_o,
  input logic          kill_o,
  input logic          halt_o,
  input logic          irq_o,
  input logic [AW-1:0] cmd_ptr_o,
  input logic          cp_load_i,
  input logic          wait_hit_i,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o
);

  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    xfer_start_o |=> !xfer_start_o);

  assert_kill_keeps_ptr_R4: assert property (@(posedge clk) disable iff (rst)
    kill_o |-> ($stable(cmd_ptr_o) && !xfer_start_o));

  assert_stop_keeps_ptr_R5: assert property (@(posedge clk) disable iff (rst)
    halt_o |-> $stable(cmd_ptr_o));

  assert_word_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  assert_wait_holds_ptr_R12: assert property (@(posedge clk) disable iff (rst)
    !$stable(cmd_ptr_o) |-> ($past(cp_load_i) || !$past(wait_hit_i)));

  assert_irq_pulse_R13: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

endmodule

bind desc_seq dsq_check #(.AW(AW)) u_chk (.*);

// File: tb/tb_desc_seq.sv
module tb_desc_seq;

  logic        clk, rst;
  logic        run_i, active_i, wake_set_i, cp_load_i, wait_gate;
  logic [31:0] cp_val_i, cmd_ptr_o;
  logic        bt_o, irq_o, kill_o, halt_o;
  logic [15:0] cur_cmd_o;
  logic        wait_hit_i, branch_hit_i, irq_hit_i;
  logic        mem_req_o, mem_we_o, mem_ack_i;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic [3:0]  mem_be_o;
  logic        xfer_start_o, xfer_out_o, xfer_last_o, xfer_done_i;
  logic [31:0] xfer_addr_o;
  logic [15:0] xfer_len_o, xfer_resid_i;

  desc_seq dut (.*);

  // condition evaluator model: selector value 2'b01 means "true"
  assign irq_hit_i    = (cur_cmd_o[5:4] == 2'b01);
  assign branch_hit_i = (cur_cmd_o[3:2] == 2'b01);
  assign wait_hit_i   = (cur_cmd_o[1:0] == 2'b01) && wait_gate;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int vecs = 0, errs = 0;
  int rd_cnt = 0, wr_cnt = 0, kill_cnt = 0, halt_cnt = 0, irq_cnt = 0;
  int start_cnt = 0, hit_c8 = 0, dcnt = 0;
  logic irq_prev = 1'b0;
  logic [31:0] mem [0:127];
  logic [67:0] wq [$];
  logic [49:0] sq [$];

  task automatic chk(input bit ok, input string req, input logic [67:0] act, input logic [67:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [15:0] cmd, input logic [15:0] cnt,
                     input logic [31:0] da, input logic [31:0] dep);
    mem[a>>2]     = {cmd, cnt};
    mem[(a>>2)+1] = da;
    mem[(a>>2)+2] = dep;
    mem[(a>>2)+3] = 32'h0;
  endtask

  // command = {op, 1'b0, key, 2'b00, irq_sel, br_sel, wait_sel}
  function automatic logic [15:0] mk(input logic [3:0] op, input logic [2:0] key,
                                     input logic [1:0] irq, input logic [1:0] br, input logic [1:0] wt);
    return {op, 1'b0, key, 2'b00, irq, br, wt};
  endfunction

  task automatic preload();
    for (int i = 0; i < 128; i++) mem[i] = 32'h0;
    put(32'h00, mk(4'd0, 3'd0, 2'd0, 2'd0, 2'd0), 16'h0040, 32'h1000, 32'h0);
    put(32'h10, mk(4'd3, 3'd1, 2'd1, 2'd1, 2'd0), 16'h0020, 32'h2000, 32'h40);
    put(32'h40, mk(4'd6, 3'd0, 2'd0, 2'd0, 2'd0), 16'h0000, 32'h0, 32'h0);
    put(32'h50, mk(4'd5, 3'd6, 2'd0, 2'd0, 2'd0), 16'h0002, 32'h1C0, 32'hAABB1234);
    put(32'h60, mk(4'd4, 3'd6, 2'd0, 2'd0, 2'd0), 16'h0001, 32'h1C4, 32'h11223344);
    put(32'h70, mk(4'd5, 3'd2, 2'd0, 2'd0, 2'd0), 16'h0004, 32'h1C8, 32'hDEADBEEF);
    put(32'h80, mk(4'd1, 3'd0, 2'd0, 2'd0, 2'd1), 16'h0008, 32'h4000, 32'h0);
    put(32'h90, mk(4'd0, 3'd0, 2'd0, 2'd0, 2'd0), 16'h0004, 32'h0, 32'h0);
    put(32'hA0, mk(4'hB, 3'd0, 2'd0, 2'd0, 2'd0), 16'h0004, 32'h5000, 32'h0);
    put(32'hB0, mk(4'd2, 3'd5, 2'd0, 2'd0, 2'd0), 16'h0004, 32'h3000, 32'h0);
    put(32'hC0, mk(4'd7, 3'd0, 2'd0, 2'd0, 2'd0), 16'h0000, 32'h0, 32'h0);
    mem[32'h1C4 >> 2] = 32'h556677EE;
  endtask

  // memory, device and scoreboard monitor
  always @(negedge clk) begin
    if (rst) begin
      mem_ack_i    <= 1'b0;
      mem_rdata_i  <= 32'h0;
      xfer_done_i  <= 1'b0;
      xfer_resid_i <= 16'h0;
      dcnt         = 0;
      preload();
    end else begin
      if (mem_req_o && !mem_ack_i) begin
        mem_ack_i <= 1'b1;
        if (mem_addr_o == 32'h1C8) hit_c8++;
        if (mem_we_o) begin
          wr_cnt++;
          for (int b = 0; b < 4; b++)
            if (mem_be_o[b]) mem[mem_addr_o[8:2]][8*b +: 8] = mem_wdata_o[8*b +: 8];
          if (wq.size() == 0)
            chk(1'b0, "R6 unexpected write", {mem_addr_o, mem_wdata_o, mem_be_o}, 68'h0);
          else begin
            logic [67:0] e;
            e = wq.pop_front();
            chk({mem_addr_o, mem_wdata_o, mem_be_o} == e, "R6/R8/R9 memory write",
                {mem_addr_o, mem_wdata_o, mem_be_o}, e);
          end
        end else begin
          rd_cnt++;
          mem_rdata_i <= mem[mem_addr_o[8:2]];
        end
      end else begin
        mem_ack_i <= 1'b0;
      end
      xfer_done_i <= 1'b0;
      if (xfer_start_o) begin
        start_cnt++;
        dcnt = 3;
        xfer_resid_i <= xfer_len_o >> 1;
        if (sq.size() == 0)
          chk(1'b0, "R3 unexpected start", {18'h0, xfer_out_o, xfer_last_o, xfer_addr_o, xfer_len_o}, 68'h0);
        else begin
          logic [49:0] s;
          s = sq.pop_front();
          chk({xfer_out_o, xfer_last_o, xfer_addr_o, xfer_len_o} == s, "R3 transfer start",
              {18'h0, xfer_out_o, xfer_last_o, xfer_addr_o, xfer_len_o}, {18'h0, s});
        end
      end else if (dcnt != 0) begin
        if (dcnt == 1) xfer_done_i <= 1'b1;
        dcnt--;
      end
      if (kill_o) kill_cnt++;
      if (halt_o) halt_cnt++;
      if (irq_o) irq_cnt++;
      if (irq_o && irq_prev) chk(1'b0, "R13 irq wider than one cycle", 68'd1, 68'd0);
      irq_prev = irq_o;
    end
  end

  task automatic wait_ptr(input logic [31:0] v);
    while (cmd_ptr_o !== v) @(negedge clk);
  endtask

  task automatic load_ptr(input logic [31:0] v);
    @(negedge clk);
    cp_val_i  = v;
    cp_load_i = 1'b1;
    @(negedge clk);
    cp_load_i = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    vecs++;
    errs++;
    $display("FAIL R2 watchdog expired act=hung exp=chain finished");
    summary();
  end

  initial begin
    rst = 1'b1; run_i = 1'b0; active_i = 1'b0; wake_set_i = 1'b0;
    cp_load_i = 1'b0; cp_val_i = 32'h0; wait_gate = 1'b1;
    repeat (4) @(negedge clk);
    chk(!mem_req_o && !xfer_start_o && !kill_o && !halt_o && !irq_o && cmd_ptr_o == 0 && !bt_o,
        "R1 reset state", {mem_req_o, xfer_start_o, kill_o, halt_o, irq_o, bt_o, cmd_ptr_o}, 68'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_req_o && cmd_ptr_o == 0 && !bt_o, "R1 after release",
        {mem_req_o, bt_o, cmd_ptr_o}, 68'h0);

    // R14: pointer load ignored while active
    active_i = 1'b1;
    load_ptr(32'h100);
    @(negedge clk);
    chk(cmd_ptr_o == 32'h0, "R14 load while active ignored", cmd_ptr_o, 68'h0);
    chk(rd_cnt == 0, "R2 no fetch without run", rd_cnt, 68'h0);
    active_i = 1'b0;

    // scoreboard expectations (R7: wake dropped on first write-back)
    wq.push_back({32'h0C, 32'h0003_0020, 4'hF});
    wq.push_back({32'h1C, 32'h0003_0010, 4'hF});
    wq.push_back({32'h1C0, 32'hAABB1234, 4'h3});
    wq.push_back({32'h68, 32'h112233EE, 4'hF});
    wq.push_back({32'h8C, 32'h0007_0004, 4'hF});
    sq.push_back({1'b1, 1'b0, 32'h1000, 16'h0040});
    sq.push_back({1'b0, 1'b1, 32'h2000, 16'h0020});
    sq.push_back({1'b1, 1'b1, 32'h4000, 16'h0008});

    // R7 collision: wake set on the edge that starts the first fetch
    @(negedge clk);
    run_i = 1'b1; active_i = 1'b1; wake_set_i = 1'b1;
    @(negedge clk);
    wake_set_i = 1'b0;

    wait_ptr(32'h10);
    chk(!bt_o, "R11 step clears bt", bt_o, 68'h0);
    wait_ptr(32'h40);
    chk(bt_o, "R11 branch sets bt", bt_o, 68'h1);
    wait_ptr(32'h50);
    chk(!bt_o, "R11 nop without branch steps", bt_o, 68'h0);
    wait_ptr(32'h80);
    chk(hit_c8 == 0, "R10 foreign-key store skipped", hit_c8, 68'h0);

    // R7: wake set during a transfer shows in its write-back
    while (!(xfer_start_o && xfer_addr_o == 32'h4000)) @(negedge clk);
    wake_set_i = 1'b1;
    @(negedge clk);
    wake_set_i = 1'b0;
    while (wr_cnt < 5) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(cmd_ptr_o == 32'h80, "R12 pointer held during wait", cmd_ptr_o, 68'h80);
    wait_gate = 1'b0;
    wait_ptr(32'h90);
    chk(cmd_ptr_o == 32'h90, "R12 released after wait", cmd_ptr_o, 68'h90);

    // R4 kills
    while (kill_cnt < 1) @(negedge clk);
    chk(cmd_ptr_o == 32'h90, "R4 zero address kill keeps pointer", cmd_ptr_o, 68'h90);
    active_i = 1'b0;
    load_ptr(32'hA0);
    chk(cmd_ptr_o == 32'hA0, "R14 load while inactive", cmd_ptr_o, 68'hA0);
    active_i = 1'b1;
    while (kill_cnt < 2) @(negedge clk);
    chk(cmd_ptr_o == 32'hA0, "R4 unknown opcode kill", cmd_ptr_o, 68'hA0);
    active_i = 1'b0;
    load_ptr(32'hB0);
    active_i = 1'b1;
    while (kill_cnt < 3) @(negedge clk);
    chk(start_cnt == 3, "R4 stream key kill starts nothing", start_cnt, 68'd3);
    active_i = 1'b0;
    load_ptr(32'hC0);
    active_i = 1'b1;

    // R5 stop
    while (halt_cnt < 1) @(negedge clk);
    chk(cmd_ptr_o == 32'hC0, "R5 stop keeps pointer", cmd_ptr_o, 68'hC0);
    begin
      int r;
      r = rd_cnt;
      repeat (10) @(negedge clk);
      chk(rd_cnt == r, "R5 no refetch while still active", rd_cnt, r);
    end
    active_i = 1'b0;
    repeat (4) @(negedge clk);

    chk(rd_cnt == 45, "R2 descriptor read count", rd_cnt, 68'd45);
    chk(irq_cnt == 1, "R13 interrupt count", irq_cnt, 68'd1);
    chk(kill_cnt == 3, "R4 kill count", kill_cnt, 68'd3);
    chk(wq.size() == 0, "R6 all writes seen", wq.size(), 68'd0);
    chk(sq.size() == 0, "R3 all starts seen", sq.size(), 68'd0);
    chk(mem[32'h1C0 >> 2] == 32'h00001234, "R9 halfword store lanes", mem[32'h1C0 >> 2], 68'h1234);
    chk(mem[32'h68 >> 2] == 32'h112233EE, "R8 byte load merged", mem[32'h68 >> 2], 68'h112233EE);
    summary();
  end

endmodule